// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Ring Engine

This block is the hardware half of a network controller's transmit and receive descriptor rings. The descriptors live in a local RAM that software also writes. Each ring has `DEPTH` entries, and each entry takes two 32-bit words. Word 0 carries a 16-bit status field in bits 31:16 and a 16-bit length in bits 15:0. Word 1 carries the 32-bit buffer address. The engine reaches this RAM through one master port with a read latency of one cycle. The word address is {ring bit (0 = transmit, 1 = receive), entry index, word select}.

On the transmit side, the engine walks its own ring index. When it finds a descriptor with the ready bit set, it places the buffer address, length and control bits on a frame-request interface. It then waits for the MAC's completion pulse, writes the completion status into the descriptor and gives ownership back to software. Three of the errors (late collision, retry limit and underrun) halt transmission until a restart pulse arrives.

On the receive side, each frame result reported by the MAC is written into the current empty descriptor. If that descriptor is not empty, the frame is dropped and a busy event is raised. Both paths raise bits in an event register that software clears by writing 1. The event register is combined with a mask to form an interrupt.

Top module: `bd_ring_engine`

## Requirements
- R1: Status bit 15 (word bit 31) set in a transmit descriptor means it is ready. The engine drives `txReq` with `txBufAddr` = word 1, `txLen` = word 0 bits 15:0, `txPad` = status bit 14, `txLast` = status bit 11 and `txCrc` = status bit 10, and holds all of them steady until `txDone`.
- R2: If the transmit descriptor at the current index is not ready, no request is made and the index does not advance. The same entry is read again until it becomes ready.
- R3: On `txDone` the transmit descriptor's word 0 is rewritten. The ready bit is cleared, status bits 14:10 and the length are kept, and status bits 9:0 take `txStat`. In `txStat`, bits 9:6 are the retry count, and bits 5 to 0 are deferred, heartbeat, late collision, retry limit, underrun and carrier lost.
- R4: In either ring, an entry whose status bit 13 (wrap) is set sends the index back to entry 0 next. Otherwise the index steps by one.
- R5: A completion with late collision, retry limit or underrun sets `txHalted` and event bit 2. After that no further `txReq` is made until a `restart` pulse clears the halt.
- R6: Status bit 15 set in a receive descriptor means it is empty. When a frame result arrives, that descriptor's word 0 becomes: bit 15 = 0, wrap and interrupt bits (13, 12) kept, last (11) = 1, first (10) = 1, bits 9:6 = 0, bits 5:0 = `rxErr`, and length = `rxLen`, which counts the 4 CRC bytes. The `rxErr` bits are, from 5 down to 0: too long, non-octet, too short, CRC error, overrun, collision.
- R7: A frame result that meets a non-empty receive descriptor is dropped. The descriptor and the receive index are left unchanged, and event bit 3 (busy) is set.
- R8: Event bits are set as follows: bit 0 when a receive descriptor with its interrupt bit (status 12) is filled, bit 1 when a transmit descriptor with its interrupt bit completes, bit 2 on a halting transmit error, bit 3 on busy. Set bits stay set until a 1 on `evtClr` clears them, and a set in the same cycle wins over the clear.
- R9: `irq` is high exactly when some event bit is set whose `evtMask` bit is also set.
- R10: A transmit completion and a receive frame result arriving in the same cycle are both written back, and both of their events are raised.
- R11: After reset, `txReq`, `txHalted`, `events` and `irq` are all low, and both ring indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ramRd | output | 1 | Descriptor RAM read strobe |
| ramWr | output | 1 | Descriptor RAM write strobe |
| ramAddr | output | log2(DEPTH)+2 | Descriptor RAM word address |
| ramWdata | output | 32 | Descriptor RAM write data |
| ramRdata | input | 32 | Read data, valid one cycle after `ramRd` |
| txReq | output | 1 | Transmit frame request |
| txBufAddr | output | 32 | Buffer address of the requested frame |
| txLen | output | 16 | Buffer length |
| txPad | output | 1 | Pad short frame |
| txCrc | output | 1 | Append CRC |
| txLast | output | 1 | Last buffer of frame |
| txDone | input | 1 | Transmit completion pulse |
| txStat | input | 10 | Completion status (retry count and error flags) |
| txHalted | output | 1 | Transmit halted by an error |
| restart | input | 1 | Pulse that clears a transmit halt |
| rxValid | input | 1 | Receive frame result pulse |
| rxLen | input | 16 | Received length, CRC included |
| rxErr | input | 6 | Receive error flags |
| evtClr | input | 4 | Write-1-to-clear strobe for events |
| evtMask | input | 4 | Interrupt enable per event |
| events | output | 4 | Event register |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act in the same cycle. In one case the engine sets an event while software clears that same bit. The bench provokes this with the transmitter halted, so the receive writeback lands two edges after `rxValid`. It raises `evtClr` for exactly that edge and expects the bit to stay set. In the other case a transmit completion and a receive frame result arrive on the same edge. The bench drives both together and then checks both descriptors in its RAM model and both event bits.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int LEN_W   = 16;
  localparam int TXST_W  = 10;
  localparam int RXERR_W = 6;
  localparam int NUM_EV  = 4;

  // status bit positions inside word 0 (status occupies bits 31:16)
  localparam int B_OWN   = 31;
  localparam int B_PAD   = 30;
  localparam int B_WRAP  = 29;
  localparam int B_INT   = 28;
  localparam int B_LAST  = 27;
  localparam int B_CRC   = 26;

  localparam int EV_RXF = 0;
  localparam int EV_TXB = 1;
  localparam int EV_TXE = 2;
  localparam int EV_BSY = 3;

  typedef enum logic [1:0] {SEL_TXW0 = 2'd0, SEL_TXW1 = 2'd1, SEL_RXW0 = 2'd2} ramSel_e;

  typedef struct packed {
    logic    rd;
    logic    wr;
    ramSel_e sel;
    logic    txLoadW0;
    logic    txLaunch;
    logic    txFinish;
    logic    rxFinish;
    logic    rxBusy;
  } strobe_t;
endpackage

// File: rtl/bdr_ctrl.sv
module bdr_ctrl
  import bdr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxPend,
  input  logic    txDonePend,
  input  logic    txActive,
  input  logic    txHalted,
  input  logic    descOwn,
  output strobe_t stb
);
  typedef enum logic [1:0] {S_IDLE, S_TXCHK, S_TXADDR, S_RXCHK} state_e;
  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    stb.sel   = SEL_TXW0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (rxPend) begin
          stb.rd = 1'b1; stb.sel = SEL_RXW0; nextState = S_RXCHK;
        end else if (txDonePend) begin
          stb.wr = 1'b1; stb.sel = SEL_TXW0; stb.txFinish = 1'b1;
        end else if (!txActive && !txHalted) begin
          stb.rd = 1'b1; stb.sel = SEL_TXW0; nextState = S_TXCHK;
        end
      end
      S_TXCHK: begin
        if (descOwn) begin
          stb.txLoadW0 = 1'b1; stb.rd = 1'b1; stb.sel = SEL_TXW1;
          nextState = S_TXADDR;
        end else begin
          nextState = S_IDLE;
        end
      end
      S_TXADDR: begin
        stb.txLaunch = 1'b1; nextState = S_IDLE;
      end
      S_RXCHK: begin
        stb.sel = SEL_RXW0;
        if (descOwn) begin
          stb.wr = 1'b1; stb.rxFinish = 1'b1;
        end else begin
          stb.rxBusy = 1'b1;
        end
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/bdr_datapath.sv
module bdr_datapath
  import bdr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int RAM_AW = IDX_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  output logic                ramRd,
  output logic                ramWr,
  output logic [RAM_AW-1:0]   ramAddr,
  output logic [31:0]         ramWdata,
  input  logic [31:0]         ramRdata,
  output logic                txReq,
  output logic [31:0]         txBufAddr,
  output logic [LEN_W-1:0]    txLen,
  output logic                txPad,
  output logic                txCrc,
  output logic                txLast,
  input  logic                txDone,
  input  logic [TXST_W-1:0]   txStat,
  output logic                txHalted,
  input  logic                restart,
  input  logic                rxValid,
  input  logic [LEN_W-1:0]    rxLen,
  input  logic [RXERR_W-1:0]  rxErr,
  input  logic [NUM_EV-1:0]   evtClr,
  input  logic [NUM_EV-1:0]   evtMask,
  output logic [NUM_EV-1:0]   events,
  output logic                irq,
  output logic                rxPend,
  output logic                txDonePend,
  output logic                descOwn
);
  logic [IDX_W-1:0]   txIdx, rxIdx;
  logic [31:0]        txW0q, txAddrq;
  logic [TXST_W-1:0]  txStatq;
  logic [LEN_W-1:0]   rxLenq;
  logic [RXERR_W-1:0] rxErrq;
  logic               txActive;
  logic [NUM_EV-1:0]  evSet;
  logic               haltErr, rxTake, rxDrop;
  logic [31:0]        txWord, rxWord;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] cur, input logic wrapBit);
    if (wrapBit || cur == IDX_W'(DEPTH - 1)) return '0;
    return cur + 1'b1;
  endfunction

  assign descOwn = ramRdata[B_OWN];
  assign haltErr = txStatq[3] | txStatq[2] | txStatq[1];
  assign rxTake  = stb.rxFinish | stb.rxBusy;
  assign rxDrop  = rxValid & rxPend & ~rxTake;

  assign txWord = {1'b0, txW0q[B_PAD:B_CRC], txStatq, txW0q[LEN_W-1:0]};
  assign rxWord = {2'b00, ramRdata[B_WRAP], ramRdata[B_INT], 1'b1, 1'b1, 4'b0000, rxErrq, rxLenq};

  assign ramRd    = stb.rd;
  assign ramWr    = stb.wr;
  assign ramAddr  = (stb.sel == SEL_RXW0) ? {1'b1, rxIdx, 1'b0}
                                          : {1'b0, txIdx, stb.sel == SEL_TXW1};
  assign ramWdata = (stb.sel == SEL_RXW0) ? rxWord : txWord;

  assign txReq     = txActive;
  assign txBufAddr = txAddrq;
  assign txLen     = txW0q[LEN_W-1:0];
  assign txPad     = txW0q[B_PAD];
  assign txCrc     = txW0q[B_CRC];
  assign txLast    = txW0q[B_LAST];

  always_comb begin
    evSet         = '0;
    evSet[EV_RXF] = stb.rxFinish & ramRdata[B_INT];
    evSet[EV_TXB] = stb.txFinish & txW0q[B_INT];
    evSet[EV_TXE] = stb.txFinish & haltErr;
    evSet[EV_BSY] = stb.rxBusy | rxDrop;
  end

  assign irq = |(events & evtMask);

  // transmit side
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txIdx <= '0; txW0q <= '0; txAddrq <= '0; txStatq <= '0;
      txActive <= 1'b0; txDonePend <= 1'b0; txHalted <= 1'b0;
    end else begin
      if (stb.txLoadW0) txW0q <= ramRdata;
      if (stb.txLaunch) begin
        txAddrq  <= ramRdata;
        txActive <= 1'b1;
      end
      if (txDone && txActive) begin
        txActive   <= 1'b0;
        txDonePend <= 1'b1;
        txStatq    <= txStat;
      end
      if (restart) txHalted <= 1'b0;
      if (stb.txFinish) begin
        txDonePend <= 1'b0;
        txIdx      <= stepIdx(txIdx, txW0q[B_WRAP]);
        if (haltErr) txHalted <= 1'b1;
      end
    end
  end

  // receive side and events
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIdx <= '0; rxPend <= 1'b0; rxLenq <= '0; rxErrq <= '0; events <= '0;
    end else begin
      if (rxTake) rxPend <= 1'b0;
      if (rxValid && (!rxPend || rxTake)) begin
        rxPend <= 1'b1;
        rxLenq <= rxLen;
        rxErrq <= rxErr;
      end
      if (stb.rxFinish) rxIdx <= stepIdx(rxIdx, ramRdata[B_WRAP]);
      events <= (events & ~evtClr) | evSet;
    end
  end
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
  import bdr_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int RAM_AW = IDX_W + 2
) (
  input  logic                clk,
  input  logic                rstN,
  output logic                ramRd,
  output logic                ramWr,
  output logic [RAM_AW-1:0]   ramAddr,
  output logic [31:0]         ramWdata,
  input  logic [31:0]         ramRdata,
  output logic                txReq,
  output logic [31:0]         txBufAddr,
  output logic [LEN_W-1:0]    txLen,
  output logic                txPad,
  output logic                txCrc,
  output logic                txLast,
  input  logic                txDone,
  input  logic [TXST_W-1:0]   txStat,
  output logic                txHalted,
  input  logic                restart,
  input  logic                rxValid,
  input  logic [LEN_W-1:0]    rxLen,
  input  logic [RXERR_W-1:0]  rxErr,
  input  logic [NUM_EV-1:0]   evtClr,
  input  logic [NUM_EV-1:0]   evtMask,
  output logic [NUM_EV-1:0]   events,
  output logic                irq
);
  strobe_t stb;
  logic    rxPend, txDonePend, descOwn;

  bdr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxPend(rxPend), .txDonePend(txDonePend),
    .txActive(txReq), .txHalted(txHalted), .descOwn(descOwn), .stb(stb)
  );

  bdr_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .ramRd(ramRd), .ramWr(ramWr), .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .txReq(txReq), .txBufAddr(txBufAddr), .txLen(txLen), .txPad(txPad), .txCrc(txCrc),
    .txLast(txLast), .txDone(txDone), .txStat(txStat), .txHalted(txHalted), .restart(restart),
    .rxValid(rxValid), .rxLen(rxLen), .rxErr(rxErr), .evtClr(evtClr), .evtMask(evtMask),
    .events(events), .irq(irq), .rxPend(rxPend), .txDonePend(txDonePend), .descOwn(descOwn)
  );
endmodule

// File: rtl/bd_ring_engine_chk.sv
module bd_ring_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        txReq,
  input logic        txDone,
  input logic [31:0] txBufAddr,
  input logic [15:0] txLen,
  input logic        txHalted,
  input logic        restart,
  input logic [3:0]  events,
  input logic [3:0]  evtClr,
  input logic        irq,
  input logic        ramWr,
  input logic        ramWordSel,
  input logic [31:0] ramWdata
);
  // R1: request and its fields hold until completion
  assert_tx_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txDone |=> txReq && $stable(txBufAddr) && $stable(txLen));

  // R3: every writeback hands ownership back to software
  assert_own_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    ramWr |-> !ramWdata[31]);

  // R6: writebacks only touch the status/length word
  assert_status_word_R6: assert property (@(posedge clk) disable iff (!rstN)
    ramWr |-> !ramWordSel);

  // R5: the halt persists until a restart pulse
  assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    txHalted && !restart |=> txHalted);

  // R8: a set event bit falls only when cleared
  assert_event_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    |events |=> ((($past(events) & ~$past(evtClr)) & ~events) == 4'b0000));

  // R9: no interrupt without a pending event
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    events == 4'b0000 |-> !irq);
endmodule

bind bd_ring_engine bd_ring_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .txReq(txReq), .txDone(txDone), .txBufAddr(txBufAddr),
  .txLen(txLen), .txHalted(txHalted), .restart(restart), .events(events), .evtClr(evtClr),
  .irq(irq), .ramWr(ramWr), .ramWordSel(ramAddr[0]), .ramWdata(ramWdata)
);

// File: tb/sim_bd_ring_engine.sv
module sim_bd_ring_engine;
  localparam int DEPTH = 128;
  localparam int AW = $clog2(DEPTH) + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, ramRd, ramWr, txReq, txPad, txCrc, txLast, txDone, txHalted, restart, rxValid, irq;
  logic [AW-1:0] ramAddr;
  logic [31:0] ramWdata, ramRdata, txBufAddr;
  logic [15:0] txLen, rxLen;
  logic [9:0]  txStat;
  logic [5:0]  rxErr;
  logic [3:0]  evtClr, evtMask, events;

  bd_ring_engine #(.DEPTH(DEPTH)) u0 (.*);

  // descriptor RAM model, single process
  logic [31:0] mem [0:4*DEPTH-1];
  logic tbWe, tbClr;
  logic [AW-1:0] tbAddr;
  logic [31:0] tbData;
  always @(posedge clk) begin
    if (tbClr) begin
      for (int i = 0; i < 4*DEPTH; i++) mem[i] <= '0;
    end else begin
      if (ramWr) mem[ramAddr] <= ramWdata;
      if (tbWe)  mem[tbAddr]  <= tbData;
    end
    if (ramRd) ramRdata <= mem[ramAddr];
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk); tbWe = 1'b1; tbAddr = AW'(a); tbData = d;
    @(negedge clk); tbWe = 1'b0;
  endtask

  task automatic evClear(input logic [3:0] v);
    @(negedge clk); evtClr = v;
    @(negedge clk); evtClr = '0;
  endtask

  task automatic waitTxReq(input string req);
    int n = 0;
    while (!txReq && n < 500) begin @(negedge clk); n++; end
    chk(req, {31'b0, txReq}, 32'd1);
  endtask

  function automatic int txA(input int idx); return idx * 2; endfunction
  function automatic int rxA(input int idx); return 2 * DEPTH + idx * 2; endfunction

  function automatic logic [31:0] txDesc(input logic pad, wrap, intb, last, crc, input logic [15:0] len);
    return {1'b1, pad, wrap, intb, last, crc, 10'b0, len};
  endfunction
  function automatic logic [31:0] txWb(input logic [31:0] d, input logic [9:0] st);
    return {1'b0, d[30:26], st, d[15:0]};
  endfunction
  function automatic logic [31:0] rxWb(input logic wrap, intb, input logic [5:0] err, input logic [15:0] len);
    return {2'b00, wrap, intb, 1'b1, 1'b1, 4'b0000, err, len};
  endfunction

  // one transmit frame at idx, completed with status st
  task automatic txFrame(input int idx, input logic [31:0] d, input logic [31:0] a,
                         input logic [9:0] st, input string req);
    poke(txA(idx) + 1, a);
    poke(txA(idx), d);
    waitTxReq(req);
    chk({req, " addr"}, txBufAddr, a);
    chk({req, " len"}, {16'b0, txLen}, {16'b0, d[15:0]});
    chk({req, " ctl"}, {29'b0, txPad, txCrc, txLast}, {29'b0, d[30], d[26], d[27]});
    @(negedge clk); txDone = 1'b1; txStat = st;
    @(negedge clk); txDone = 1'b0;
    cyc(5);
    chk("R3 writeback", mem[txA(idx)], txWb(d, st));
  endtask

  task automatic rxFrame(input logic [15:0] len, input logic [5:0] err);
    @(negedge clk); rxValid = 1'b1; rxLen = len; rxErr = err;
    @(negedge clk); rxValid = 1'b0;
    cyc(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int txIdx, rxIdx;
    logic [31:0] d, a;
    logic [9:0] st;
    logic wrap, intb;
    logic [15:0] len;
    logic [5:0] err;
    void'($urandom(32'd2024));
    rstN = 1'b0; tbClr = 1'b1; tbWe = 1'b0; tbAddr = '0; tbData = '0;
    txDone = 1'b0; txStat = '0; restart = 1'b0; rxValid = 1'b0; rxLen = '0; rxErr = '0;
    evtClr = '0; evtMask = '0;
    cyc(4);
    tbClr = 1'b0;
    @(negedge clk); rstN = 1'b1;
    cyc(2);

    // R11 reset state
    chk("R11 txReq", {31'b0, txReq}, 32'd0);
    chk("R11 txHalted", {31'b0, txHalted}, 32'd0);
    chk("R11 events", {28'b0, events}, 32'd0);
    chk("R11 irq", {31'b0, irq}, 32'd0);

    // R1 R3 R4 R8 R9: random transmit frames
    txIdx = 0;
    evtMask = 4'b0010;
    for (int k = 0; k < 10; k++) begin
      wrap = ($urandom % 4) == 0;
      intb = $urandom % 2;
      len  = 16'($urandom_range(64, 1518));
      d    = txDesc($urandom % 2, wrap, intb, $urandom % 2, $urandom % 2, len);
      a    = $urandom & 32'hFFFF_FFFC;
      st   = 10'($urandom) & 10'h3F1;
      evClear(4'hF);
      txFrame(txIdx, d, a, st, "R1 request");
      chk("R8 txBuf event", {28'b0, events}, {30'b0, intb, 1'b0});
      chk("R9 irq", {31'b0, irq}, {31'b0, intb});
      txIdx = wrap ? 0 : txIdx + 1;   // R4
    end
    evtMask = 4'b0000;
    cyc(1);
    chk("R9 masked irq", {31'b0, irq}, 32'd0);

    // R2: not-ready entry polled in place
    cyc(30);
    chk("R2 no request", {31'b0, txReq}, 32'd0);
    d = txDesc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd100);
    txFrame(txIdx, d, 32'hABCD_0010, 10'h000, "R2 same entry");
    txIdx++;

    // R5: underrun halts transmit
    evClear(4'hF);
    d = txDesc(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'd60);
    txFrame(txIdx, d, 32'h0000_2000, 10'h002, "R5 request");
    txIdx++;
    chk("R5 halted", {31'b0, txHalted}, 32'd1);
    chk("R5 txErr event", {28'b0, events}, 32'h4);
    poke(txA(txIdx) + 1, 32'h0000_3000);
    poke(txA(txIdx), txDesc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd80));
    cyc(30);
    chk("R5 no request while halted", {31'b0, txReq}, 32'd0);

    // R6 R4: random receive frames
    rxIdx = 0;
    for (int k = 0; k < 6; k++) begin
      wrap = ($urandom % 3) == 0;
      intb = $urandom % 2;
      len  = 16'($urandom_range(68, 1522));
      err  = 6'($urandom);
      poke(rxA(rxIdx), {1'b1, 1'b0, wrap, intb, 28'b0});
      evClear(4'hF);
      rxFrame(len, err);
      chk("R6 rx writeback", mem[rxA(rxIdx)], rxWb(wrap, intb, err, len));
      chk("R8 rxFrame event", {28'b0, events}, {31'b0, intb});
      rxIdx = wrap ? 0 : rxIdx + 1;
    end

    // R7: busy descriptor
    poke(rxA(rxIdx), 32'h1000_0055);
    evClear(4'hF);
    rxFrame(16'd64, 6'd0);
    chk("R7 busy event", {28'b0, events}, 32'h8);
    chk("R7 descriptor unchanged", mem[rxA(rxIdx)], 32'h1000_0055);
    poke(rxA(rxIdx), {4'b1001, 28'b0});
    rxFrame(16'd90, 6'd1);
    chk("R7 index held", mem[rxA(rxIdx)], rxWb(1'b0, 1'b1, 6'd1, 16'd90));
    rxIdx++;

    // R8: set wins over a clear in the same cycle
    poke(rxA(rxIdx), {4'b1001, 28'b0});
    evClear(4'hF);
    @(negedge clk); rxValid = 1'b1; rxLen = 16'd70; rxErr = '0;
    @(negedge clk); rxValid = 1'b0;
    @(negedge clk); evtClr = 4'b1001;
    @(negedge clk); evtClr = 4'b0000;
    chk("R8 set wins", {28'b0, events}, 32'h1);
    evClear(4'b0001);
    chk("R8 clear", {28'b0, events}, 32'h0);
    rxIdx++;

    // R5 restart, then R10 simultaneous completion and receive
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    waitTxReq("R5 resumes");
    chk("R5 halt cleared", {31'b0, txHalted}, 32'd0);
    chk("R5 resumed addr", txBufAddr, 32'h0000_3000);
    poke(rxA(rxIdx), {4'b1001, 28'b0});
    evClear(4'hF);
    @(negedge clk); txDone = 1'b1; txStat = 10'h0C0; rxValid = 1'b1; rxLen = 16'd200; rxErr = 6'h20;
    @(negedge clk); txDone = 1'b0; rxValid = 1'b0;
    cyc(8);
    chk("R10 tx writeback", mem[txA(txIdx)], txWb(txDesc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'd80), 10'h0C0));
    chk("R10 rx writeback", mem[rxA(rxIdx)], rxWb(1'b0, 1'b1, 6'h20, 16'd200));
    chk("R10 events", {28'b0, events}, 32'h3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule